// File: doc/BRIEF.md
# Instruction Halfword Realignment Buffer

This block sits between a source that delivers 32-bit instruction words at word-aligned addresses and a fetch stage that takes instructions of either 16 or 32 bits, each starting on any halfword boundary. It holds one 16-bit side register with the upper halfword of the last word it took in. From that register and the incoming word it forms a 32-bit window that starts at the current instruction address. The downstream stage reads the low 16 bits of the window for a short instruction and the full 32 bits for a long one.

The block also keeps the program counter of the instruction it presents, and it merges the error flags of the words that supply the window. A redirect input loads a new halfword-aligned address and drops any held halfword. Upstream words arrive with a valid/ready handshake, and the instruction window leaves with its own valid/ready handshake. When the side register alone holds a whole short instruction, the block presents it without taking a new word.

Top module: `instr_realign`

## Requirements
- R1: A halfword starts a short (16-bit) instruction when its bits [1:0] are not 2'b11. Otherwise it is the first half of a long (32-bit) instruction.
- R2: With the address word-aligned and no halfword held, the window is the incoming word unchanged. A short instruction in its low half is presented, and the word is taken (`up_ready` follows `dn_ready`).
- R3: While the held halfword is a complete short instruction, `dn_valid` is 1 whatever `up_valid` is, `up_ready` is 0, and `dn_data[15:0]` is the held halfword.
- R4: While the held halfword is the first half of a long instruction, `dn_data` is {incoming low halfword, held halfword} and `dn_valid` follows `up_valid`. The held register then keeps its valid state and reloads with the new word's upper halfword.
- R5: When the address has bit 1 set and nothing is held, the window is the incoming word with its halfwords swapped. If the upper halfword is a long-instruction start, `dn_valid` is 0, `up_ready` is 1, and that halfword is held instead.
- R6: A redirect in a cycle clears the held halfword. It also loads the address from `redirect_addr` with bit 0 forced to 0, and no transfer happens on either side in that cycle.
- R7: Each instruction taken downstream (`dn_valid` and `dn_ready`) advances `dn_addr` by 2 if it is short and by 4 if it is long. Otherwise the address holds.
- R8: `dn_err` is the incoming word's error when no halfword is held. It is the held halfword's stored error for a short instruction from the held register alone, and the OR of both for a long instruction that spans them.
- R9: While `dn_valid` is 1 and `dn_ready` is 0, the presented address and window do not change.
- R10: After reset nothing is held, `dn_addr` is 0, and `dn_valid` is 0 while `up_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Upstream word valid |
| up_data | input | 32 | Upstream instruction word |
| up_err | input | 1 | Error flag of the upstream word |
| up_ready | output | 1 | Block takes the upstream word |
| dn_valid | output | 1 | Instruction window valid |
| dn_data | output | 32 | Instruction window, first halfword in bits [15:0] |
| dn_addr | output | 32 | Address of the presented instruction |
| dn_err | output | 1 | Error of the halfwords the instruction uses |
| dn_ready | input | 1 | Downstream takes the instruction |
| redirect | input | 1 | Load a new instruction address |
| redirect_addr | input | 32 | New instruction address |

## Verification
The hardest states to reach are a long instruction that straddles two words right after a redirect to an odd halfword, and a held short instruction that must be emitted while upstream stalls. Both need a particular run of bit patterns across consecutive words. Directed sequences drive each of them once with known words. A long random run then walks a halfword memory filled with a mix of short and long starts, using random redirects, upstream gaps and downstream stalls. A reference walker checks every taken instruction, its address and its error against that memory.

// File: rtl/rlgn_pkg.sv
package rlgn_pkg;

  // A halfword starts a short instruction unless both low bits are set.
  function automatic logic is_short(input logic [1:0] low_bits);
    return low_bits != 2'b11;
  endfunction

  // Byte distance from one instruction start to the next.
  function automatic logic [2:0] step_bytes(input logic short_instr);
    return short_instr ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/rlgn_skid_reg.sv
module rlgn_skid_reg #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              load_valid,
  input  logic [HALF_W-1:0] load_half,
  input  logic              load_err,
  input  logic              consume,
  output logic              held_valid,
  output logic [HALF_W-1:0] held_half,
  output logic              held_err
);

  logic valid_q;
  logic [HALF_W-1:0] half_q;
  logic err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      half_q  <= '0;
      err_q   <= 1'b0;
    end else if (clear) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= load_valid;
      half_q  <= load_half;
      err_q   <= load_err;
    end else if (consume) begin
      valid_q <= 1'b0;
    end
  end

  assign held_valid = valid_q;
  assign held_half  = half_q;
  assign held_err   = err_q;

  // R4: a held halfword stays held unless consumed or cleared
  a_r4_held_persists: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid && !clear && !consume |=> held_valid);

  // R6: clear always empties the register
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !held_valid);

endmodule

// File: rtl/rlgn_pc_track.sv
module rlgn_pc_track
  import rlgn_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              branch,
  input  logic [ADDR_W-1:0] target,
  input  logic              advance,
  input  logic              short_instr,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] HALF_MASK = ~{{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] step_ext;

  assign step_ext = {{(ADDR_W-3){1'b0}}, step_bytes(short_instr)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (branch) begin
      pc_q <= target & HALF_MASK;
    end else if (advance) begin
      pc_q <= pc_q + step_ext;
    end
  end

  assign pc = pc_q;

  // R6: redirect loads the halfword-aligned target
  a_r6_redirect_loads: assert property (@(posedge clk) disable iff (!rst_n)
    branch |=> pc == ($past(target) & HALF_MASK));

  // R7: without a transfer or redirect the address holds
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !branch && !advance |=> $stable(pc));

  // R1: the address never becomes odd
  a_r1_halfword_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[0] == 1'b0);

endmodule

// File: rtl/rlgn_out_mux.sv
module rlgn_out_mux
  import rlgn_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                held_valid,
  input  logic [HALF_W-1:0]   held_half,
  input  logic                held_err,
  input  logic                addr_odd_half,
  input  logic                in_valid,
  input  logic [2*HALF_W-1:0] in_word,
  input  logic                in_err,
  input  logic                out_ready,
  input  logic                branch,
  output logic                out_valid,
  output logic [2*HALF_W-1:0] out_window,
  output logic                out_err,
  output logic                in_ready,
  output logic                cur_short,
  output logic                held_short
);

  logic [HALF_W-1:0] in_lo;
  logic [HALF_W-1:0] in_hi;
  logic upper_short;
  logic valid_raw;
  logic ready_raw;

  assign in_lo       = in_word[HALF_W-1:0];
  assign in_hi       = in_word[2*HALF_W-1:HALF_W];
  assign upper_short = is_short(in_hi[1:0]);
  assign held_short  = held_valid && is_short(held_half[1:0]);

  always_comb begin
    if (held_short) begin
      valid_raw  = 1'b1;
      out_window = {{HALF_W{1'b0}}, held_half};
      out_err    = held_err;
      ready_raw  = 1'b0;
      cur_short  = 1'b1;
    end else if (held_valid) begin
      valid_raw  = in_valid;
      out_window = {in_lo, held_half};
      out_err    = in_err | held_err;
      ready_raw  = out_ready;
      cur_short  = 1'b0;
    end else if (!addr_odd_half) begin
      valid_raw  = in_valid;
      out_window = in_word;
      out_err    = in_err;
      ready_raw  = out_ready;
      cur_short  = is_short(in_lo[1:0]);
    end else begin
      valid_raw  = in_valid && upper_short;
      out_window = {in_lo, in_hi};
      out_err    = in_err;
      ready_raw  = out_ready || !upper_short;
      cur_short  = upper_short;
    end
  end

  assign out_valid = valid_raw && !branch;
  assign in_ready  = ready_raw && !branch;

  // R3: a held short instruction is presented without taking a word
  a_r3_held_short_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    held_short && !branch |-> out_valid && !in_ready);

  // R5: an odd entry on a long start takes the word silently
  a_r5_odd_long_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
    !held_valid && addr_odd_half && in_valid && !upper_short && !branch
      |-> !out_valid && in_ready);

  // R6: nothing moves in a redirect cycle
  a_r6_no_transfer_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    branch |-> !out_valid && !in_ready);

endmodule

// File: rtl/instr_realign.sv
module instr_realign #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_valid,
  input  logic [2*HALF_W-1:0] up_data,
  input  logic                up_err,
  output logic                up_ready,
  output logic                dn_valid,
  output logic [2*HALF_W-1:0] dn_data,
  output logic [ADDR_W-1:0]   dn_addr,
  output logic                dn_err,
  input  logic                dn_ready,
  input  logic                redirect,
  input  logic [ADDR_W-1:0]   redirect_addr
);

  localparam int unsigned WORD_W = 2 * HALF_W;

  logic              held_valid;
  logic [HALF_W-1:0] held_half;
  logic              held_err;
  logic              cur_short;
  logic              held_short;
  logic              word_taken;
  logic              instr_taken;
  logic              skid_load_valid;
  logic [WORD_W-1:0] window;

  // Named events for the checks below
  assign word_taken      = up_valid && up_ready;
  assign instr_taken     = dn_valid && dn_ready;
  assign skid_load_valid = dn_addr[1] ^ cur_short;

  rlgn_out_mux #(.HALF_W(HALF_W)) u_mux (
    .clk          (clk),
    .rst_n        (rst_n),
    .held_valid   (held_valid),
    .held_half    (held_half),
    .held_err     (held_err),
    .addr_odd_half(dn_addr[1]),
    .in_valid     (up_valid),
    .in_word      (up_data),
    .in_err       (up_err),
    .out_ready    (dn_ready),
    .branch       (redirect),
    .out_valid    (dn_valid),
    .out_window   (window),
    .out_err      (dn_err),
    .in_ready     (up_ready),
    .cur_short    (cur_short),
    .held_short   (held_short)
  );

  rlgn_skid_reg #(.HALF_W(HALF_W)) u_skid (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (redirect),
    .load      (word_taken),
    .load_valid(skid_load_valid),
    .load_half (up_data[WORD_W-1:HALF_W]),
    .load_err  (up_err),
    .consume   (instr_taken && held_short),
    .held_valid(held_valid),
    .held_half (held_half),
    .held_err  (held_err)
  );

  rlgn_pc_track #(.ADDR_W(ADDR_W)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .branch     (redirect),
    .target     (redirect_addr),
    .advance    (instr_taken),
    .short_instr(cur_short),
    .pc         (dn_addr)
  );

  assign dn_data = window;

  // R7: a taken short instruction moves the address by two
  a_r7_short_step: assert property (@(posedge clk) disable iff (!rst_n)
    instr_taken && (dn_data[1:0] != 2'b11) |=> dn_addr == $past(dn_addr) + 2);

  // R7: a taken long instruction moves the address by four
  a_r7_long_step: assert property (@(posedge clk) disable iff (!rst_n)
    instr_taken && (dn_data[1:0] == 2'b11) |=> dn_addr == $past(dn_addr) + 4);

  // R9: a stalled instruction keeps its address and window
  a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready && !redirect |=> $stable(dn_addr));

  // R4: a held long start implies an odd-half address
  a_r4_held_means_odd: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid |-> dn_addr[1]);

endmodule

// File: tb/instr_realign_tb_top.sv
module instr_realign_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0, up_err = 1'b0, up_ready;
  logic [31:0] up_data = '0;
  logic dn_valid, dn_err, dn_ready = 1'b0;
  logic [31:0] dn_data, dn_addr;
  logic redirect = 1'b0;
  logic [31:0] redirect_addr = '0;

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [WORDS];
  logic        werr [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_realign dut_i (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_data(up_data), .up_err(up_err), .up_ready(up_ready),
    .dn_valid(dn_valid), .dn_data(dn_data), .dn_addr(dn_addr), .dn_err(dn_err),
    .dn_ready(dn_ready), .redirect(redirect), .redirect_addr(redirect_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic iv, input logic [31:0] d, input logic e,
                       input logic ordy, input logic br, input logic [31:0] tgt);
    @(negedge clk);
    up_valid = iv; up_data = d; up_err = e; dn_ready = ordy;
    redirect = br; redirect_addr = tgt;
    #2;
  endtask

  function automatic logic [15:0] mh(input int h);
    int hw = h & (2*WORDS-1);
    return hw[0] ? mem[hw>>1][31:16] : mem[hw>>1][15:0];
  endfunction

  function automatic logic eh(input int h);
    int hw = h & (2*WORDS-1);
    return werr[hw>>1];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp_addr;
    logic [31:0] fptr;
    logic [31:0] stall_data;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10 reset state
    drive(0, 0, 0, 0, 0, 0);
    chk("R10 valid", 32'(dn_valid), 0);
    chk("R10 addr", dn_addr, 0);

    // R2 aligned word, short low half
    drive(1, 32'h0005_0009, 0, 1, 0, 0);
    chk("R2 valid", 32'(dn_valid), 1);
    chk("R2 data", 32'(dn_data[15:0]), 32'h0009);
    chk("R2 ready", 32'(up_ready), 1);
    // R3 held short instruction alone
    drive(0, 0, 0, 1, 0, 0);
    chk("R3 valid", 32'(dn_valid), 1);
    chk("R3 ready", 32'(up_ready), 0);
    chk("R3 data", 32'(dn_data[15:0]), 32'h0005);
    chk("R7 addr+2", dn_addr, 2);
    drive(0, 0, 0, 1, 0, 0);
    chk("R3 consumed", 32'(dn_valid), 0);
    chk("R7 addr+2 again", dn_addr, 4);

    // R4 / R8 long instruction spanning words
    drive(1, 32'h1233_0001, 0, 1, 0, 0);
    chk("R2 data short", 32'(dn_data[15:0]), 32'h0001);
    drive(1, 32'h5678_4567, 1, 0, 0, 0);
    chk("R4 valid", 32'(dn_valid), 1);
    chk("R4 data", dn_data, 32'h4567_1233);
    chk("R8 merged err", 32'(dn_err), 1);
    stall_data = dn_data;
    drive(1, 32'h5678_4567, 1, 0, 0, 0);
    chk("R9 addr hold", dn_addr, 6);
    chk("R9 data hold", dn_data, stall_data);
    drive(1, 32'h5678_4567, 1, 1, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R7 addr+4", dn_addr, 10);
    chk("R4 held next", 32'(dn_data[15:0]), 32'h5678);
    chk("R8 held err", 32'(dn_err), 1);

    // R6 redirect clears held halfword
    drive(0, 0, 0, 1, 1, 32'h23);
    drive(0, 0, 0, 1, 0, 0);
    chk("R6 cleared", 32'(dn_valid), 0);
    chk("R6 addr", dn_addr, 32'h22);

    // R5 odd entry on a long start
    drive(1, 32'h3333_0001, 0, 1, 0, 0);
    chk("R5 no valid", 32'(dn_valid), 0);
    chk("R5 absorbs", 32'(up_ready), 1);
    drive(1, 32'h0000_4444, 0, 1, 0, 0);
    chk("R5 span valid", 32'(dn_valid), 1);
    chk("R5 span data", dn_data, 32'h4444_3333);
    drive(0, 0, 0, 0, 0, 0);
    chk("R7 addr+4 odd", dn_addr, 32'h26);

    // R5 odd entry on a short start: swapped halves
    drive(0, 0, 0, 1, 1, 32'h42);
    drive(1, 32'h0006_FFFF, 0, 1, 0, 0);
    chk("R5 rot valid", 32'(dn_valid), 1);
    chk("R5 rot data", dn_data, 32'hFFFF_0006);
    drive(0, 0, 0, 1, 0, 0);
    chk("R1 short step", dn_addr, 32'h44);
    chk("R1 nothing left", 32'(dn_valid), 0);

    // Random mixed stream against a reference walker
    for (int i = 0; i < WORDS; i++) begin
      logic [31:0] w = $urandom;
      if ($urandom % 2) w[1:0] = 2'b11;
      if ($urandom % 2) w[17:16] = 2'b11;
      mem[i] = w;
      werr[i] = ($urandom % 10) == 0;
    end
    exp_addr = 0;
    fptr = 0;
    for (int cyc = 0; cyc < 30000; cyc++) begin
      logic br = (cyc == 0) || (($urandom % 40) == 0);
      logic [31:0] tgt = $urandom % 512;
      logic iv = ($urandom % 10) < 7;
      logic ordy = ($urandom % 10) < 7;
      drive(iv, mem[fptr % WORDS], werr[fptr % WORDS], ordy, br, tgt);
      if (br) begin
        exp_addr = tgt & ~32'h1;
        fptr = tgt >> 2;
      end else begin
        if (dn_valid && dn_ready) begin
          int h = int'(exp_addr >> 1);
          logic [15:0] lo = mh(h);
          logic shrt = lo[1:0] != 2'b11;
          chk("R7 stream addr", dn_addr, exp_addr);
          if (shrt) begin
            chk("R1 stream short", 32'(dn_data[15:0]), 32'(lo));
            chk("R8 stream err", 32'(dn_err), 32'(eh(h)));
          end else begin
            chk("R4 stream long", dn_data, {mh(h+1), lo});
            chk("R8 stream err", 32'(dn_err), 32'(eh(h) | eh(h+1)));
          end
          exp_addr = exp_addr + (shrt ? 2 : 4);
        end
        if (up_valid && up_ready) fptr = fptr + 1;
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule